// File: doc/BRIEF.md
# Truncating float-to-int32 converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer of `INT_W` bits (32 by default). The operand comes in as a class code, a sign, a signed unbiased exponent and a normalised mantissa whose top bit is the explicit leading one. The conversion always truncates toward zero, whatever rounding mode the rest of the arithmetic unit uses. Any fraction that is thrown away raises an inexact flag. Results that cannot be represented saturate to a value chosen by the sign and raise an invalid flag.

The datapath is one combinational stage followed by one output register. A request presented with `in_valid` high produces its result with `out_valid` high on the next clock. When no request arrives, the registered result keeps its value. The mantissa is aligned by a logarithmic right shifter that ORs every bit it discards into a sticky bit. A range stage then checks the magnitude against the asymmetric two's-complement limits and picks the final value and flags.

Top module: `fti_conv`

## Requirements
- R1: A class code of 0 (zero) gives a result of 0 with inexact and invalid both low, for either sign.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. While `in_valid` stays low the registered result and flags hold their values. After reset the result, both flags and `out_valid` are 0.
- R3: For class code 1 (number) with a positive sign and an exponent from 0 to `INT_W`-2, the result is the integer part of mantissa × 2^(exp-(MANT_W-1)). Inexact is high exactly when a non-zero bit lies below the binary point.
- R4: A negative number that is in range gives the two's-complement negation of its truncated magnitude, so that -2.75 becomes -2. Inexact follows the same rule as R3.
- R5: A number with a negative exponent gives 0 and raises inexact when its mantissa is non-zero.
- R6: A number with an exponent of `INT_W` or more is an overflow.
- R7: A truncated magnitude of 2^(INT_W-1) or more overflows when the sign is positive. With a negative sign, a truncated magnitude of exactly 2^(INT_W-1) is valid and gives 0x80000000, and anything larger overflows.
- R8: On overflow, and for class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN), inexact is low and invalid is high. The result is 0x7FFFFFFF for a positive sign and 0x80000000 for a negative sign.
- R9: The unused class codes 5 to 7 are converted like a NaN, as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign of the operand, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, leading one at bit MANT_W-1 |
| out_valid | output | 1 | Result register loaded in the previous cycle |
| out_result | output | INT_W | Converted integer |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Overflow, infinity or NaN; result saturated |

## Verification
The bench concentrates on the asymmetric edge of the range. At +2^31 it expects saturation, while -2^31 must pass cleanly. A converter with a symmetric limit would flag the most negative integer as invalid, and one that ignored the sign would let +2^31 wrap to a negative number. The bench also checks -2^31 - 0.5, which must truncate to the minimum with inexact set. A design that compared the magnitude before truncation would overflow on that input. Exponents of -1 and far below, and of exactly 31, 32 and far above, catch a shifter that lost its sticky bit or misjudged its shift amount. The special classes check that inexact is dropped when invalid is raised, and that the saturated value follows the sign.

// File: rtl/fti_pkg.sv
package fti_pkg;

    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_class_e;

endpackage

// File: rtl/fti_align.sv
// Right-aligns the mantissa so the integer part lands in the low INT_W bits.
// Every bit pushed off the bottom is collected into a sticky bit.
module fti_align #(
    parameter int MANT_W = 64,
    parameter int INT_W  = 32,
    parameter int EXP_W  = 12
) (
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  exp_in,
    output logic [MANT_W-1:0] shifted,
    output logic              sticky,
    output logic              exp_big
);
    localparam int SH_W  = $clog2(MANT_W + 1);
    localparam int IDX_W = $clog2(INT_W);

    logic              exp_neg;
    logic [SH_W-1:0]   amt;
    logic [MANT_W-1:0] lvl [0:SH_W];
    logic              stk [0:SH_W];

    always_comb begin
        exp_neg = exp_in[EXP_W-1];
        exp_big = !exp_neg && (exp_in >= EXP_W'(INT_W));
        if (exp_neg) begin
            amt = SH_W'(MANT_W);
        end else if (exp_big) begin
            amt = '0;
        end else begin
            amt = SH_W'(MANT_W - 1) - SH_W'(exp_in[IDX_W-1:0]);
        end
    end

    assign lvl[0] = mant;
    assign stk[0] = 1'b0;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 2 ** k;
        if (STEP >= MANT_W) begin : g_full
            assign lvl[k+1] = amt[k] ? '0 : lvl[k];
            assign stk[k+1] = stk[k] | (amt[k] & (|lvl[k]));
        end else begin : g_part
            localparam logic [MANT_W-1:0] LOW = {{(MANT_W-STEP){1'b0}}, {STEP{1'b1}}};
            assign lvl[k+1] = amt[k] ? (lvl[k] >> STEP) : lvl[k];
            assign stk[k+1] = stk[k] | (amt[k] & (|(lvl[k] & LOW)));
        end
    end

    assign shifted = lvl[SH_W];
    assign sticky  = stk[SH_W];

endmodule

// File: rtl/fti_sat.sv
// Range check, sign application and saturation.
module fti_sat #(
    parameter int MANT_W = 64,
    parameter int INT_W  = 32
) (
    input  logic [2:0]        cls,
    input  logic              sign,
    input  logic              exp_big,
    input  logic [MANT_W-1:0] shifted,
    input  logic              sticky,
    output logic [INT_W-1:0]  result,
    output logic              inexact,
    output logic              invalid
);
    import fti_pkg::*;

    logic [INT_W-1:0] mag;
    logic [INT_W:0]   limit;
    logic             high_bits;
    logic             too_big;
    logic [INT_W-1:0] sat_val;

    always_comb begin
        mag       = shifted[INT_W-1:0];
        high_bits = |shifted[MANT_W-1:INT_W];
        // magnitude limit is 2^(INT_W-1), one more when negative
        limit     = {2'b01, {(INT_W-1){1'b0}}} + (INT_W+1)'(sign);
        too_big   = exp_big | high_bits | ({1'b0, mag} >= limit);
        sat_val   = sign ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};

        result  = '0;
        inexact = 1'b0;
        invalid = 1'b0;
        case (fp_class_e'(cls))
            CLS_ZERO: begin
                result = '0;
            end
            CLS_NUM: begin
                if (too_big) begin
                    result  = sat_val;
                    invalid = 1'b1;
                end else begin
                    result  = sign ? (~mag + INT_W'(1)) : mag;
                    inexact = sticky;
                end
            end
            default: begin
                result  = sat_val;
                invalid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fti_conv.sv
module fti_conv #(
    parameter int MANT_W = 64,
    parameter int INT_W  = 32,
    parameter int EXP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic              out_inexact,
    output logic              out_invalid
);
    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] result;
        logic             nx;
        logic             nv;
    } state_t;

    state_t st_d, st_q;

    logic [MANT_W-1:0] al_shifted;
    logic              al_sticky;
    logic              al_big;
    logic [INT_W-1:0]  cv_result;
    logic              cv_nx;
    logic              cv_nv;

    fti_align #(.MANT_W(MANT_W), .INT_W(INT_W), .EXP_W(EXP_W)) u_align (
        .mant    (in_mant),
        .exp_in  (in_exp),
        .shifted (al_shifted),
        .sticky  (al_sticky),
        .exp_big (al_big)
    );

    fti_sat #(.MANT_W(MANT_W), .INT_W(INT_W)) u_sat (
        .cls     (in_class),
        .sign    (in_sign),
        .exp_big (al_big),
        .shifted (al_shifted),
        .sticky  (al_sticky),
        .result  (cv_result),
        .inexact (cv_nx),
        .invalid (cv_nv)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = cv_result;
            st_d.nx     = cv_nx;
            st_d.nv     = cv_nv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_inexact = st_q.nx;
    assign out_invalid = st_q.nv;

endmodule

// File: rtl/fti_conv_chk.sv
module fti_conv_chk #(
    parameter int MANT_W = 64,
    parameter int INT_W  = 32,
    parameter int EXP_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_class,
    input logic              in_sign,
    input logic [EXP_W-1:0]  in_exp,
    input logic [MANT_W-1:0] in_mant,
    input logic              out_valid,
    input logic [INT_W-1:0]  out_result,
    input logic              out_inexact,
    input logic              out_invalid
);
    localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));

    // R1
    zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd0) |=> (out_result == '0 && !out_inexact && !out_invalid));

    // R3
    pos_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd1 && !in_sign) |=> !out_result[INT_W-1]);

    // R5
    neg_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd1 && in_exp[EXP_W-1] && (|in_mant))
        |=> (out_result == '0 && out_inexact && !out_invalid));

    // R6
    big_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd1 && !in_exp[EXP_W-1] && in_exp >= EXP_W'(INT_W))
        |=> out_invalid);

    // R8
    special_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class >= 3'd2 && !in_sign)
        |=> (out_result == POS_SAT && out_invalid && !out_inexact));

    // R8
    special_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class >= 3'd2 && in_sign)
        |=> (out_result == NEG_SAT && out_invalid && !out_inexact));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_inexact && out_invalid));

    // R8
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == POS_SAT || out_result == NEG_SAT));

endmodule

bind fti_conv fti_conv_chk #(.MANT_W(MANT_W), .INT_W(INT_W), .EXP_W(EXP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_sign     (in_sign),
    .in_exp      (in_exp),
    .in_mant     (in_mant),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
);

// File: tb/fti_conv_bench.sv
`timescale 1ns/1ps
module fti_conv_bench;
    localparam int MANT_W = 64;
    localparam int INT_W  = 32;
    localparam int EXP_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [2:0]        in_class = '0;
    logic              in_sign = 1'b0;
    logic [EXP_W-1:0]  in_exp = '0;
    logic [MANT_W-1:0] in_mant = '0;
    logic              out_valid;
    logic [INT_W-1:0]  out_result;
    logic              out_inexact;
    logic              out_invalid;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] res;
        logic        nx;
        logic        nv;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    fti_conv #(.MANT_W(MANT_W), .INT_W(INT_W), .EXP_W(EXP_W)) u_fti_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_class    (in_class),
        .in_sign     (in_sign),
        .in_exp      (in_exp),
        .in_mant     (in_mant),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_inexact (out_inexact),
        .out_invalid (out_invalid)
    );

    task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [2:0] c, input logic s, input int e, input logic [63:0] m,
                        input logic [31:0] r, input logic x, input logic v, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_class = c;
        in_sign  = s;
        in_exp   = e[EXP_W-1:0];
        in_mant  = m;
        sb.push_back('{res: r, nx: x, nv: v, tag: tag});
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", 34'(out_result), 34'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({out_result, out_inexact, out_invalid} == {e.res, e.nx, e.nv}, e.tag,
                          {out_result, out_inexact, out_invalid}, {e.res, e.nx, e.nv});
                end
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check(!out_valid && out_result == 0 && !out_inexact && !out_invalid, "R2 reset state",
              {out_result, out_inexact, out_invalid}, 34'(0));
        rst_n = 1'b1;

        send(3'd0, 1'b0, 0, '0, 32'h0, 1'b0, 1'b0, "R1 +zero");
        send(3'd0, 1'b1, 5, '0, 32'h0, 1'b0, 1'b0, "R1 -zero");
        send(3'd1, 1'b0, 0, ONE, 32'h1, 1'b0, 1'b0, "R3 +1.0");
        send(3'd1, 1'b0, 0, 64'hC000_0000_0000_0000, 32'h1, 1'b1, 1'b0, "R3 +1.5");
        send(3'd1, 1'b0, 6, 64'hF600_0000_0000_0000, 32'd123, 1'b0, 1'b0, "R3 +123");
        send(3'd1, 1'b0, 30, 64'hFFFF_FFFE_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, "R3 +(2^31-1)");
        send(3'd1, 1'b0, 30, 64'hFFFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R3 just below 2^31");
        send(3'd1, 1'b1, 30, 64'hFFFF_FFFE_0000_0000, 32'h8000_0001, 1'b0, 1'b0, "R4 -(2^31-1)");
        send(3'd1, 1'b1, 1, 64'hB000_0000_0000_0000, 32'hFFFF_FFFE, 1'b1, 1'b0, "R4 -2.75");
        send(3'd1, 1'b0, -1, ONE, 32'h0, 1'b1, 1'b0, "R5 +0.5");
        send(3'd1, 1'b1, -1, ONE, 32'h0, 1'b1, 1'b0, "R5 -0.5");
        send(3'd1, 1'b0, -200, ONE, 32'h0, 1'b1, 1'b0, "R5 tiny");
        send(3'd1, 1'b0, 32, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1, "R6 +2^32");
        send(3'd1, 1'b1, 1000, 64'hFFFF_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1, "R6 -huge");
        send(3'd1, 1'b0, 31, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1, "R7 +2^31");
        send(3'd1, 1'b1, 31, ONE, 32'h8000_0000, 1'b0, 1'b0, "R7 -2^31");
        send(3'd1, 1'b1, 31, 64'h8000_0000_8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R7 -2^31-0.5");
        send(3'd1, 1'b1, 31, 64'h8000_0001_0000_0000, 32'h8000_0000, 1'b0, 1'b1, "R7 -(2^31+1)");
        send(3'd2, 1'b0, 0, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1, "R8 +inf");
        send(3'd2, 1'b1, 0, ONE, 32'h8000_0000, 1'b0, 1'b1, "R8 -inf");
        send(3'd3, 1'b0, 0, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1, "R8 +qnan");
        send(3'd4, 1'b1, 0, ONE, 32'h8000_0000, 1'b0, 1'b1, "R8 -snan");
        send(3'd6, 1'b0, 0, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1, "R9 code 6");
        send(3'd7, 1'b1, 3, ONE, 32'h8000_0000, 1'b0, 1'b1, "R9 code 7");
        send(3'd1, 1'b0, 6, 64'hF600_0000_0000_0000, 32'd123, 1'b0, 1'b0, "R3 +123 again");
        idle();
        // R2: with no request the result holds and out_valid stays low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!out_valid && out_result == 32'd123 && !out_inexact && !out_invalid, "R2 hold",
                  {out_valid, out_result, out_invalid}, {1'b0, 32'd123, 1'b0});
        end
        check(sb.size() == 0, "R2 all results seen", 34'(sb.size()), 34'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule